// File: doc/BRIEF.md
# Selectable Divide-by-5/6 Johnson Stage

This block is the first stage of a line-frequency time base. It keeps a three-bit twisted-ring (Johnson) counter in the system clock domain. The counter advances once for each count strobe. Each strobe is a one-clock pulse that stands for one falling edge of the mains input, already shaped and synchronised upstream. A select input picks the modulus at run time. With select low the ring walks all six Johnson states and gives a symmetric square wave. With select high one state is skipped, so the period is five counts with an asymmetric waveform.

An enable input freezes the ring without losing its position. A clear input, sampled on the clock, forces the ring back to the zero count and wins over every other input. A carry output pulses for one system clock whenever a count step returns the ring to zero. The next divider stage can therefore take one step per output period of this stage. The ring never rests in a non-Johnson pattern: any such pattern goes to zero on the next count.

Top module: `line_div56_stage`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the ring goes to zero, so `wave_out` and `period_tick` both read 0 after the edge.
- R2: Each rising clock edge with `cnt_strobe`=1, `cnt_en`=1 and `clear`=0 moves the ring exactly one Johnson step. Without a strobe the ring does not move.
- R3: While `cnt_en` is 0, strobes are ignored: the ring and `wave_out` keep their values and `period_tick` stays 0.
- R4: `clear`=1 at a clock edge puts the ring at zero after that edge, even if a strobe and enable are present in the same cycle. No carry is produced by it.
- R5: With `div_five`=0 the ring runs through 000, 001, 011, 111, 110, 100 and back to 000. `wave_out` is ring bit 1, so it is 0 for 3 counts and 1 for 3 counts in a 6-count period.
- R6: With `div_five`=1, state 100 is skipped (110 steps to 000). The period is 5 counts, with `wave_out` 0 for 2 counts and 1 for 3 counts.
- R7: `period_tick` is 1 for exactly the one clock after a count step that lands the ring on 000, and 0 in all other cycles.
- R8: The ring never holds 010 or 101. Any such pattern steps to 000 on the next count.
- R9: If `div_five` rises while the ring sits at 100, the next count goes to 000 and raises `period_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| cnt_strobe | input | 1 | One-clock pulse per falling edge of the line input |
| cnt_en | input | 1 | Count enable; low holds the ring |
| clear | input | 1 | Synchronous clear of the ring to zero, highest priority |
| div_five | input | 1 | 1 selects divide-by-5, 0 selects divide-by-6 |
| wave_out | output | 1 | Divided output waveform (ring bit 1) |
| period_tick | output | 1 | One-clock carry after the ring wraps to zero |

## Verification
Two cases can fall on the same clock edge. In the first, a clear arrives together with a strobe that would otherwise wrap the ring and raise the carry. The bench drives both in one cycle and expects zero count with no carry. In the second, the select changes in the same cycle as a strobe, including while the ring sits at 100, the state that only divide-by-6 may enter. A bench model built from the state lists in R5 and R6 judges every cycle. The stimulus is directed cases and a seeded random run in which clear, enable and select toggle freely against the strobe.

// File: rtl/div56_pkg.sv
// Shared types for the divide-by-5/6 Johnson stage.
// Assumes a three-bit ring; the output tap and skip rule rely on that width.
package div56_pkg;
    localparam int RING_W  = 3;
    localparam int OUT_TAP = RING_W - 2;

    typedef logic [RING_W-1:0] ring_t;

    typedef enum logic {
        MODE_DIV6 = 1'b0,
        MODE_DIV5 = 1'b1
    } div_mode_e;

    localparam ring_t RING_ZERO = '0;
    // Pattern with only the top bit set: the state dropped in five-count mode.
    localparam ring_t RING_SKIP = ring_t'(1) << (RING_W - 1);
endpackage

// File: rtl/div56_step_gate.sv
// Qualifies a count strobe into a single advance request and decodes the mode.
// Assumes cnt_strobe is already a one-clock pulse in the clk domain.
module div56_step_gate
    import div56_pkg::*;
(
    input  logic      cnt_strobe,
    input  logic      cnt_en,
    input  logic      clear,
    input  logic      div_five,
    output logic      advance,
    output div_mode_e mode
);
    // Advance only when enabled and not being cleared.
    always_comb begin
        advance = cnt_strobe && cnt_en && !clear;
        mode    = div_five ? MODE_DIV5 : MODE_DIV6;
    end
endmodule

// File: rtl/div56_ring_next.sv
// Next-state function of the twisted ring with an optional skipped state.
// Assumes cur is the registered ring; output is purely combinational.
module div56_ring_next
    import div56_pkg::*;
(
    input  ring_t     cur,
    input  div_mode_e mode,
    output ring_t     nxt,
    output logic      wraps
);
    logic  legal;
    ring_t shifted;

    // A Johnson pattern has at most one boundary between adjacent bits.
    always_comb begin
        int edges;
        edges = 0;
        for (int i = 0; i < RING_W - 1; i++) begin
            if (cur[i] != cur[i+1]) edges++;
        end
        legal = (edges <= 1);
    end

    // Twisted shift: inverted top bit enters at the bottom.
    always_comb begin
        shifted = {cur[RING_W-2:0], ~cur[RING_W-1]};
    end

    // Pick the next pattern: recover illegal rings, drop the skip state in five-count mode.
    always_comb begin
        if (!legal) begin
            nxt = RING_ZERO;
        end else if (mode == MODE_DIV5 && shifted == RING_SKIP) begin
            nxt = RING_ZERO;
        end else begin
            nxt = shifted;
        end
        wraps = (nxt == RING_ZERO);
    end
endmodule

// File: rtl/div56_ring_reg.sv
// Holds the ring and the carry flag; applies reset, clear and advance in that priority.
// Assumes advance is already masked by clear and enable.
module div56_ring_reg
    import div56_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clear,
    input  logic  advance,
    input  ring_t nxt,
    input  logic  wraps,
    output ring_t ring,
    output logic  carry
);
    // State update with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring  <= RING_ZERO;
            carry <= 1'b0;
        end else if (clear) begin
            ring  <= RING_ZERO;
            carry <= 1'b0;
        end else if (advance) begin
            ring  <= nxt;
            carry <= wraps;
        end else begin
            carry <= 1'b0;
        end
    end

    assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !clear) |=> ($stable(ring) && !carry));

    assert_clear_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (ring == RING_ZERO && !carry));

    assert_carry_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        carry |-> (ring == RING_ZERO));

    assert_carry_needs_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> !carry);
endmodule

// File: rtl/line_div56_stage.sv
// Top of the selectable divide-by-5/6 stage: gate, next-state logic and state register.
// Assumes all inputs are synchronous to clk; one strobe equals one line falling edge.
module line_div56_stage
    import div56_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cnt_strobe,
    input  logic cnt_en,
    input  logic clear,
    input  logic div_five,
    output logic wave_out,
    output logic period_tick
);
    logic      advance;
    div_mode_e mode;
    ring_t     ring;
    ring_t     nxt;
    logic      wraps;

    div56_step_gate u_gate (
        .cnt_strobe (cnt_strobe),
        .cnt_en     (cnt_en),
        .clear      (clear),
        .div_five   (div_five),
        .advance    (advance),
        .mode       (mode)
    );

    div56_ring_next u_next (
        .cur   (ring),
        .mode  (mode),
        .nxt   (nxt),
        .wraps (wraps)
    );

    div56_ring_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .advance (advance),
        .nxt     (nxt),
        .wraps   (wraps),
        .ring    (ring),
        .carry   (period_tick)
    );

    // Output tap: ring bit 1 gives 3/3 in six-count and 2 low/3 high in five-count.
    always_comb begin
        wave_out = ring[OUT_TAP];
    end

    assert_legal_ring_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ring != 3'b010) && (ring != 3'b101));

    assert_skip_in_five_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && div_five && ring == 3'b110) |=> (ring == 3'b000 && period_tick));

    assert_full_walk_six_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !div_five && ring == 3'b110) |=> (ring == 3'b100 && !period_tick));

    assert_late_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && ring == 3'b100) |=> (ring == 3'b000 && period_tick));

    assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && ring == 3'b001) |=> (ring == 3'b011));
endmodule

// File: tb/line_div56_stage_bench.sv
module line_div56_stage_bench;
    logic clk = 1'b0;
    logic rst_n, cnt_strobe, cnt_en, clear, div_five;
    logic wave_out, period_tick;

    int compared = 0;
    int mismatched = 0;
    logic [2:0] m_ring;
    logic       m_tick;
    bit         done = 0;

    always #5 clk = ~clk;

    line_div56_stage u_line_div56_stage (
        .clk (clk), .rst_n (rst_n), .cnt_strobe (cnt_strobe), .cnt_en (cnt_en),
        .clear (clear), .div_five (div_five), .wave_out (wave_out), .period_tick (period_tick)
    );

    // Expected next ring, written from the state lists of R5 and R6.
    function automatic logic [2:0] exp_next(input logic [2:0] s, input logic five);
        case (s)
            3'b000: return 3'b001;
            3'b001: return 3'b011;
            3'b011: return 3'b111;
            3'b111: return 3'b110;
            3'b110: return five ? 3'b000 : 3'b100;
            default: return 3'b000;
        endcase
    endfunction

    task automatic check(input string req, input logic act, input logic exp, input string what);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Drive one cycle at a falling edge, update the model, check after the next rising edge.
    task automatic cyc(input logic s, input logic e, input logic c, input logic f, input string req);
        cnt_strobe = s; cnt_en = e; clear = c; div_five = f;
        if (c) begin
            m_ring = 3'b000; m_tick = 1'b0;
        end else if (s && e) begin
            m_ring = exp_next(m_ring, f);
            m_tick = (m_ring == 3'b000);
        end else begin
            m_tick = 1'b0;
        end
        @(negedge clk);
        check(req, wave_out, m_ring[1], "wave_out");
        check(req == "R4" ? "R4" : "R7", period_tick, m_tick, "period_tick");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [2:0] w6 [6];
        process::self().srandom(32'd5150);
        rst_n = 1'b0; cnt_strobe = 1'b1; cnt_en = 1'b1; clear = 1'b0; div_five = 1'b0;
        m_ring = 3'b000; m_tick = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", wave_out, 1'b0, "wave_out after reset");
        check("R1", period_tick, 1'b0, "period_tick after reset");
        rst_n = 1'b1;

        // R2: no strobe, no movement; then single steps.
        repeat (3) cyc(0, 1, 0, 0, "R2");
        // R5: two full six-count periods, checking duty.
        for (int p = 0; p < 2; p++) begin
            int highs;
            highs = 0;
            for (int k = 0; k < 6; k++) begin
                cyc(1, 1, 0, 0, "R5");
                if (wave_out) highs++;
            end
            compared++;
            if (highs != 3) begin
                mismatched++;
                $display("FAIL R5 high count actual=%0d expected=3", highs);
            end
        end
        // R6: two five-count periods, 3 high counts each.
        for (int p = 0; p < 2; p++) begin
            int highs;
            highs = 0;
            for (int k = 0; k < 5; k++) begin
                cyc(1, 1, 0, 1, "R6");
                if (wave_out) highs++;
            end
            compared++;
            if (highs != 3) begin
                mismatched++;
                $display("FAIL R6 high count actual=%0d expected=3", highs);
            end
        end
        // R3: strobes with enable low hold the ring.
        repeat (2) cyc(1, 1, 0, 0, "R2");
        repeat (6) cyc(1, 0, 0, 0, "R3");
        // R9: walk to 100 in six-count mode, then raise select with the next strobe.
        cyc(0, 1, 1, 0, "R4");
        repeat (5) cyc(1, 1, 0, 0, "R5");
        cyc(1, 1, 0, 1, "R9");
        check("R9", period_tick, 1'b1, "carry after select change at 100");
        // R4: clear in the cycle a wrap would occur.
        repeat (5) cyc(1, 1, 0, 0, "R5");
        cyc(1, 1, 1, 0, "R4");
        check("R4", period_tick, 1'b0, "no carry on clear");
        cyc(1, 1, 0, 0, "R2");
        // R1: mid-run reset.
        repeat (2) cyc(1, 1, 0, 1, "R6");
        rst_n = 1'b0; @(negedge clk);
        m_ring = 3'b000; m_tick = 1'b0;
        check("R1", wave_out, 1'b0, "wave_out after mid-run reset");
        rst_n = 1'b1;

        // Random run: the model also confirms every visited ring is legal (R8).
        for (int n = 0; n < 4000; n++) begin
            logic s, e, c, f;
            s = ($urandom % 2) == 0;
            e = ($urandom % 10) != 0;
            c = ($urandom % 30) == 0;
            f = (($urandom % 20) == 0) ? ~div_five : div_five;
            cyc(s, e, c, f, c ? "R4" : (e ? "R8" : "R3"));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule